// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Sequencer

This block turns single host requests into timed cycles on an 8-bit asynchronous NAND flash bus. A request is either a write (command, address or data byte, chosen by two host address bits) or a data read. For each request the block lowers chip select and steps through setup, strobe and hold phases. It pulses the write strobe or the read strobe in the strobe phase and keeps the command-latch and address-latch enables steady for the whole access. The length of every phase comes from a fixed bit field of one 32-bit timing word. When the transfer direction reverses, an idle turnaround gap is placed before the next access.

The host side is a valid/ready request port. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold its request steady until that edge. Read results come back as a one-cycle `rsp_valid` pulse with no back-pressure, so the host must take the byte in that cycle. The flash ready/busy line goes through a two-flop synchronizer to a ready status pin. Write protect is driven from the chip-select state.

Timing word layout (bit positions matter): write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2], bus size [1:0]. Bits 31 and 30 (strobe-select mode and extended wait) and the bus size field must be zero, which selects the plain 8-bit mode. A typical setting is setup 1, write strobe 3, read strobe 5, hold 1 and turnaround 3.

Top module: `nand_bus_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `nf_cs_n`, `nf_we_n` and `nf_re_n` are 1, `nf_cle`, `nf_ale`, `nf_doe` and `rsp_valid` are 0, `nf_wp_n` is 0 and `req_ready` is 1.
- R2: An access holds `nf_cs_n` low for exactly setup+1, then strobe+1, then hold+1 clocks, taken from the write fields for a write and the read fields for a read. The first cycle with chip select low has no strobe active, and the cycle after the last strobe still has chip select low.
- R3: In the strobe phase `nf_we_n` is low only for writes and `nf_re_n` is low only for reads. Outside the strobe phase both are high.
- R4: While `nf_cs_n` is low, `nf_cle` equals `req_addr[0]` and `nf_ale` equals `req_addr[1]` of the accepted request. Both are 0 whenever `nf_cs_n` is high.
- R5: During a write access `nf_doe` is 1 and `nf_dout` carries the accepted `req_wdata`. During a read access and when idle, `nf_doe` is 0.
- R6: A read captures `nf_din` on the clock edge that ends the last strobe cycle. It presents the byte on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first hold cycle. A write never raises `rsp_valid`.
- R7: `req_ready` is 1 only when idle and 0 for the whole access. After acceptance, chip select falls on the next cycle when no turnaround is needed. `req_ready` is 1 again on the cycle after the hold phase.
- R8: When a request's direction differs from that of the previous accepted request, chip select stays high for turnaround+1 clocks before setup. With the same direction, or for the first request after reset, no gap is added.
- R9: `nf_wp_n` is 0 whenever `nf_cs_n` is high and 1 whenever `nf_cs_n` is low.
- R10: `stat_ready` follows `nf_rb` (1 = ready) through two clock stages. A change at the input shows on the output after the second rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| timing_cfg | input | 32 | Packed phase-length word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Bit 0 = command latch, bit 1 = address latch |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid (one cycle) |
| rsp_rdata | output | 8 | Read byte |
| nf_cs_n | output | 1 | Chip select, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_cle | output | 1 | Command-latch enable |
| nf_ale | output | 1 | Address-latch enable |
| nf_dout | output | 8 | Bus data out |
| nf_doe | output | 1 | Bus output enable |
| nf_din | input | 8 | Bus data in |
| nf_rb | input | 1 | Flash ready/busy, 1 = ready |
| nf_wp_n | output | 1 | Write protect, active low |
| stat_ready | output | 1 | Synchronized ready status |

## Verification
The hardest case to reach is the capture edge of a read. Seen from the pins, sampling on the last strobe clock looks the same as sampling one cycle earlier or later. The stimulus therefore changes `nf_din` on every strobe cycle to the base value plus the strobe cycle index, so only a capture at the final strobe edge returns base+strobe. The turnaround gap only shows after a direction change. Each timing setting is exercised with a write, write, read, read, write sequence, which hits both reversal directions and both same-direction cases under a sweep of phase lengths that includes zero and every field at its maximum.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int DATA_W  = 8;
  localparam int SETUP_W = 4;
  localparam int STRB_W  = 6;
  localparam int HOLD_W  = 3;
  localparam int TURN_W  = 2;
  localparam int CNT_W   = (STRB_W > SETUP_W) ? STRB_W : SETUP_W;

  // field positions in the timing word
  localparam int WS_LSB = 26;
  localparam int WT_LSB = 20;
  localparam int WH_LSB = 17;
  localparam int RS_LSB = 13;
  localparam int RT_LSB = 7;
  localparam int RH_LSB = 4;
  localparam int TA_LSB = 2;

  typedef struct packed {
    logic [SETUP_W-1:0] wr_setup;
    logic [STRB_W-1:0]  wr_strobe;
    logic [HOLD_W-1:0]  wr_hold;
    logic [SETUP_W-1:0] rd_setup;
    logic [STRB_W-1:0]  rd_strobe;
    logic [HOLD_W-1:0]  rd_hold;
    logic [TURN_W-1:0]  turn;
  } nbs_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STRB, PH_HOLD
  } nbs_phase_e;
endpackage

// File: rtl/nbs_cfg_decode.sv
module nbs_cfg_decode
  import nbs_pkg::*;
(
  input  logic [29:2]  field_bits,
  output nbs_timing_t  tim
);
  always_comb begin
    tim.wr_setup  = field_bits[WS_LSB +: SETUP_W];
    tim.wr_strobe = field_bits[WT_LSB +: STRB_W];
    tim.wr_hold   = field_bits[WH_LSB +: HOLD_W];
    tim.rd_setup  = field_bits[RS_LSB +: SETUP_W];
    tim.rd_strobe = field_bits[RT_LSB +: STRB_W];
    tim.rd_hold   = field_bits[RH_LSB +: HOLD_W];
    tim.turn      = field_bits[TA_LSB +: TURN_W];
  end
endmodule

// File: rtl/nbs_sync.sv
module nbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nbs_sequencer.sv
module nbs_sequencer
  import nbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nbs_timing_t       tim,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic              cs_n,
  output logic              we_n,
  output logic              re_n,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);
  nbs_phase_e        phase;
  logic [CNT_W-1:0]  cnt;
  logic              op_wr, op_cle, op_ale;
  logic [DATA_W-1:0] op_data;
  logic              used, last_wr;
  logic              in_acc, last_tick;

  assign in_acc    = (phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_HOLD);
  assign last_tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      op_wr     <= 1'b0;
      op_cle    <= 1'b0;
      op_ale    <= 1'b0;
      op_data   <= '0;
      used      <= 1'b0;
      last_wr   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          op_wr   <= req_write;
          op_cle  <= req_addr[0];
          op_ale  <= req_addr[1];
          op_data <= req_wdata;
          used    <= 1'b1;
          last_wr <= req_write;
          if (used && (last_wr != req_write)) begin
            phase <= PH_TURN;
            cnt   <= CNT_W'(tim.turn);
          end else begin
            phase <= PH_SETUP;
            cnt   <= req_write ? CNT_W'(tim.wr_setup) : CNT_W'(tim.rd_setup);
          end
        end
        PH_TURN: begin
          if (last_tick) begin
            phase <= PH_SETUP;
            cnt   <= op_wr ? CNT_W'(tim.wr_setup) : CNT_W'(tim.rd_setup);
          end else cnt <= cnt - 1'b1;
        end
        PH_SETUP: begin
          if (last_tick) begin
            phase <= PH_STRB;
            cnt   <= op_wr ? CNT_W'(tim.wr_strobe) : CNT_W'(tim.rd_strobe);
          end else cnt <= cnt - 1'b1;
        end
        PH_STRB: begin
          if (last_tick) begin
            phase <= PH_HOLD;
            cnt   <= op_wr ? CNT_W'(tim.wr_hold) : CNT_W'(tim.rd_hold);
            if (!op_wr) begin
              rsp_rdata <= bus_din;
              rsp_valid <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (last_tick) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign cs_n      = !in_acc;
  assign we_n      = !((phase == PH_STRB) && op_wr);
  assign re_n      = !((phase == PH_STRB) && !op_wr);
  assign cle       = in_acc && op_cle;
  assign ale       = in_acc && op_ale;
  assign bus_oe    = in_acc && op_wr;
  assign bus_dout  = op_data;

  // R2: setup phase precedes any strobe
  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (we_n && re_n));
  // R2: hold phase follows the strobe
  p_hold_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |-> !cs_n);
  // R4: latch enables steady through an access
  p_latch_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(cle) && $stable(ale)));
  // R6: response only right after a read strobe
  p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!re_n) && re_n));
  // R7: no acceptance during an access
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              nf_cs_n,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic [DATA_W-1:0] nf_dout,
  output logic              nf_doe,
  input  logic [DATA_W-1:0] nf_din,
  input  logic              nf_rb,
  output logic              nf_wp_n,
  output logic              stat_ready
);
  nbs_timing_t tim;

  nbs_cfg_decode u_dec (
    .field_bits (timing_cfg[29:2]),
    .tim        (tim)
  );

  nbs_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tim       (tim),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .bus_din   (nf_din),
    .cs_n      (nf_cs_n),
    .we_n      (nf_we_n),
    .re_n      (nf_re_n),
    .cle       (nf_cle),
    .ale       (nf_ale),
    .bus_dout  (nf_dout),
    .bus_oe    (nf_doe)
  );

  nbs_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nf_rb),
    .q     (stat_ready)
  );

  assign nf_wp_n = ~nf_cs_n;

  // R2: only the plain 8-bit mode is supported
  p_cfg_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_cfg[31:30] == 2'b00) && (timing_cfg[1:0] == 2'b00));
  // R9: protect released exactly when a chip select begins
  p_wp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_cs_n) |-> ($past(!nf_wp_n) && nf_wp_n));
endmodule

// File: tb/sim_nand_bus_seq.sv
`timescale 1ns/1ps
module sim_nand_bus_seq;
  logic clk = 0, rst_n = 0;
  logic [31:0] timing_cfg = '0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0, nf_din = '0;
  logic nf_rb = 0;
  logic req_ready, rsp_valid, nf_cs_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_doe, nf_wp_n, stat_ready;
  logic [7:0] rsp_rdata, nf_dout;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int cws, cwt, cwh, crs, crt, crh, cta;
  bit have_prev = 0, prev_wr = 0;

  always #10 clk = ~clk;

  nand_bus_seq u0 (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int ws, int wt, int wh, int rs, int rt, int rh, int ta);
    cws = ws; cwt = wt; cwh = wh; crs = rs; crt = rt; crh = rh; cta = ta;
    timing_cfg = {2'b00, 4'(ws), 6'(wt), 3'(wh), 4'(rs), 6'(rt), 3'(rh), 2'(ta), 2'b00};
  endtask

  task automatic access(bit wr, logic [1:0] a, logic [7:0] d, logic [7:0] base);
    int exp_turn, es, et, eh;
    int nt = 0, ns = 0, nst = 0, nh = 0, nrsp = 0, guard = 0;
    int bad_ctl = 0, bad_ready = 0, bad_wp = 0;
    logic [7:0] got = '0;
    bit seen = 0, fin = 0, strb = 0;
    exp_turn = (have_prev && (prev_wr != wr)) ? cta + 1 : 0;
    es = (wr ? cws : crs) + 1;
    et = (wr ? cwt : crt) + 1;
    eh = (wr ? cwh : crh) + 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!fin && guard < 400) begin
      guard++;
      if (nf_wp_n !== ~nf_cs_n) bad_wp++;
      if (rsp_valid) begin nrsp++; got = rsp_rdata; end
      if (nf_cs_n) begin
        if (seen) fin = 1; else nt++;
      end else begin
        seen = 1;
        if (req_ready) bad_ready++;
        if (nf_cle !== a[0] || nf_ale !== a[1] || nf_doe !== wr || (wr && nf_dout !== d)) bad_ctl++;
        if (!nf_we_n || !nf_re_n) begin
          if ((!nf_we_n) !== wr || (!nf_re_n) !== !wr) bad_ctl++;
          if (!wr) nf_din = 8'(base + nst);
          nst++; strb = 1;
        end else if (strb) nh++;
        else ns++;
      end
      if (!fin) @(negedge clk);
    end
    chk(fin, "R7 access did not end", guard, 0);
    chk(nt == exp_turn, "R8 turnaround length", nt, exp_turn);
    chk(ns == es, "R2 setup length", ns, es);
    chk(nst == et, "R2 strobe length", nst, et);
    chk(nh == eh, "R2 hold length", nh, eh);
    chk(bad_ctl == 0, "R3 R4 R5 strobe/latch/data pins", bad_ctl, 0);
    chk(bad_ready == 0, "R7 ready low in access", bad_ready, 0);
    chk(bad_wp == 0, "R9 write protect", bad_wp, 0);
    chk(nrsp == (wr ? 0 : 1), "R6 response pulse count", nrsp, wr ? 0 : 1);
    if (!wr) chk(got == 8'(base + crt), "R6 captured byte", got, 8'(base + crt));
    chk(req_ready === 1'b1, "R7 ready after hold", req_ready, 1);
    chk(nf_cle === 0 && nf_ale === 0 && nf_doe === 0, "R4 R5 idle pins", {nf_cle, nf_ale, nf_doe}, 0);
    have_prev = 1; prev_wr = wr;
  endtask

  task automatic sequence_run(logic [7:0] seed);
    access(1, 2'b01, seed, 8'h00);
    access(1, 2'b10, ~seed, 8'h00);
    access(0, 2'b00, 8'h00, seed ^ 8'h5A);
    access(0, 2'b00, 8'h00, seed + 8'h31);
    access(1, 2'b00, seed + 8'h07, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 3, 1, 1, 5, 1, 3);
    repeat (3) @(negedge clk);
    chk(nf_cs_n === 1 && nf_we_n === 1 && nf_re_n === 1, "R1 strobes in reset", {nf_cs_n, nf_we_n, nf_re_n}, 7);
    chk(nf_wp_n === 0 && nf_doe === 0 && rsp_valid === 0, "R1 wp/oe/rsp in reset", {nf_wp_n, nf_doe, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1 && nf_cle === 0 && nf_ale === 0, "R1 after reset", {req_ready, nf_cle, nf_ale}, 4);
    // R10 synchronizer latency
    nf_rb = 1;
    @(negedge clk);
    chk(stat_ready === 0, "R10 one edge after rise", stat_ready, 0);
    @(negedge clk);
    chk(stat_ready === 1, "R10 two edges after rise", stat_ready, 1);
    nf_rb = 0;
    @(negedge clk);
    chk(stat_ready === 1, "R10 one edge after fall", stat_ready, 1);
    @(negedge clk);
    chk(stat_ready === 0, "R10 two edges after fall", stat_ready, 0);
    nf_rb = 1;
    // typical configuration, then a sweep
    sequence_run(8'hA5);
    for (int i = 0; i < 20; i++) begin
      if (i == 19) set_cfg(15, 63, 7, 15, 63, 7, 3);
      else if (i == 0) set_cfg(0, 0, 0, 0, 0, 0, 0);
      else set_cfg(i % 5, (i * 3) % 7, i % 4, (i + 2) % 5, (i * 5) % 9, (i + 1) % 3, i % 4);
      sequence_run(8'(i * 13 + 1));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule